// File: doc/BRIEF.md
# Two-Channel Priority Handshake Receiver

This block lets one costly consumer, such as a shared divider, take words from two independent senders. Each sender reaches it over its own channel, made of a sender-driven "send ready" line, a data bus, and a receiver-driven "receive ready" line. Everything runs on one common clock. A word moves on any rising edge at which both the send-ready and the receive-ready lines of a channel are high.

On every edge the block samples both send-ready lines and registers which single channel it will accept from during the next cycle. Channel 1 wins whenever both senders offer on the same edge. Each completed transfer appears on the output for exactly one cycle, with the captured word and a one-bit tag naming the source channel. A hold input from downstream forces both receive-ready lines low at once, so no transfer can complete while the hold is high.

Top module: `hsrx_top`

## Requirements
- R1: While `rst_n` is low, both receive-ready outputs and `out_vld` are low. The reset acts asynchronously and is released on a clock edge.
- R2: If `ch1_send_rdy` is sampled high at an edge, `ch1_recv_rdy` is high during the following cycle unless `hold` is high. If only `ch2_send_rdy` is sampled high, `ch2_recv_rdy` is high instead. When both are high, channel 1 is chosen.
- R3: At most one of `ch1_recv_rdy` and `ch2_recv_rdy` is high in any cycle.
- R4: If neither send-ready line is high at an edge, both receive-ready lines are low during the following cycle.
- R5: A transfer completes on an edge where a channel's send-ready and receive-ready are both high. In the next cycle `out_vld` is high, `out_word` holds that channel's data as sampled at the completing edge, and `out_from` is 0 for channel 1 or 1 for channel 2.
- R6: When no transfer completes at an edge, `out_vld` is low in the following cycle. Data lines whose send-ready line is low are ignored.
- R7: A sender that keeps its send-ready line high and presents a new word after every completed edge moves one word per clock edge, in order.
- R8: While `hold` is high, both receive-ready lines are low in that same cycle, so no transfer completes. Once `hold` drops, a pending grant shows immediately.
- R9: The data width `DW` (default 16) applies to both input buses and to `out_word`, and all bits are carried.
- R10: A sender that drops send-ready right after its word completes causes no second capture, even though its receive-ready line is still high for one more cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch1_send_rdy | input | 1 | Channel 1 sender offers a word |
| ch1_data | input | DW | Channel 1 data |
| ch1_recv_rdy | output | 1 | Block accepts from channel 1 this cycle |
| ch2_send_rdy | input | 1 | Channel 2 sender offers a word |
| ch2_data | input | DW | Channel 2 data |
| ch2_recv_rdy | output | 1 | Block accepts from channel 2 this cycle |
| hold | input | 1 | Downstream stall; blocks all acceptance |
| out_vld | output | 1 | One-cycle pulse per completed transfer |
| out_word | output | DW | Captured word |
| out_from | output | 1 | Source tag: 0 = channel 1, 1 = channel 2 |

## Verification
The bound checker checks the following on every cycle:
- the one-hot-or-none property of the two receive-ready lines;
- the effect of hold within the same cycle;
- the grant that follows from each sampled pair of offers, including channel 1 priority;
- the exact word and tag that follow every completing edge.

Some properties depend on a sequence of events, so only the directed scenarios can show them:
- in-order streaming at one word per edge;
- hand-over from channel 1 to a waiting channel 2;
- the absence of a second capture after a sender withdraws;
- a pending grant reappearing when hold is released;
- reset taking effect in the middle of traffic.

// File: rtl/hsrx_pkg.sv
package hsrx_pkg;
  localparam int NCH = 2;
  localparam int SW  = (NCH > 1) ? $clog2(NCH) : 1;

  typedef enum logic [SW-1:0] {
    SRC_CH1 = SW'(0),
    SRC_CH2 = SW'(1)
  } src_e;
endpackage

// File: rtl/hsrx_grant.sv
module hsrx_grant
  import hsrx_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] offer,
  output logic [NCH-1:0] grant_q
);
  logic [NCH-1:0] grant_d;

  // fixed priority: the lowest index wins, so it is scanned last
  always_comb begin
    grant_d = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (offer[i]) begin
        grant_d    = '0;
        grant_d[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grant_q <= '0;
    else        grant_q <= grant_d;
  end
endmodule

// File: rtl/hsrx_capture.sv
module hsrx_capture
  import hsrx_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCH-1:0]          offer,
  input  logic [NCH-1:0]          accept,
  input  logic [NCH-1:0][DW-1:0]  data,
  output logic                    vld_q,
  output logic [DW-1:0]           word_q,
  output logic [SW-1:0]           src_q
);
  logic [NCH-1:0] done;
  logic           hit;
  logic [DW-1:0]  word_d;
  logic [SW-1:0]  src_d;

  assign done = offer & accept;
  assign hit  = |done;

  always_comb begin
    word_d = '0;
    src_d  = '0;
    for (int i = 0; i < NCH; i++) begin
      if (done[i]) begin
        word_d = data[i];
        src_d  = SW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= hit;
  end

  // payload registers are loaded only on a completing edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      src_q  <= '0;
    end else if (hit) begin
      word_q <= word_d;
      src_q  <= src_d;
    end
  end
endmodule

// File: rtl/hsrx_top.sv
module hsrx_top
  import hsrx_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ch1_send_rdy,
  input  logic [DW-1:0] ch1_data,
  output logic          ch1_recv_rdy,
  input  logic          ch2_send_rdy,
  input  logic [DW-1:0] ch2_data,
  output logic          ch2_recv_rdy,
  input  logic          hold,
  output logic          out_vld,
  output logic [DW-1:0] out_word,
  output logic          out_from
);
  logic [NCH-1:0]         offer;
  logic [NCH-1:0]         grant_q;
  logic [NCH-1:0]         accept;
  logic [NCH-1:0][DW-1:0] data;
  logic [SW-1:0]          src_q;

  assign offer   = {ch2_send_rdy, ch1_send_rdy};
  assign data[0] = ch1_data;
  assign data[1] = ch2_data;

  hsrx_grant u_grant (
    .clk     (clk),
    .rst_n   (rst_n),
    .offer   (offer),
    .grant_q (grant_q)
  );

  // stall masks the registered grant in the same cycle
  for (genvar g = 0; g < NCH; g++) begin : g_gate
    assign accept[g] = grant_q[g] & ~hold;
  end

  hsrx_capture #(.DW(DW)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .offer  (offer),
    .accept (accept),
    .data   (data),
    .vld_q  (out_vld),
    .word_q (out_word),
    .src_q  (src_q)
  );

  assign ch1_recv_rdy = accept[0];
  assign ch2_recv_rdy = accept[1];
  assign out_from     = src_q[0];
endmodule

// File: rtl/hsrx_chk.sv
module hsrx_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ch1_send_rdy,
  input logic [DW-1:0] ch1_data,
  input logic          ch1_recv_rdy,
  input logic          ch2_send_rdy,
  input logic [DW-1:0] ch2_data,
  input logic          ch2_recv_rdy,
  input logic          hold,
  input logic          out_vld,
  input logic [DW-1:0] out_word,
  input logic          out_from
);
  assert_ch1_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ch1_send_rdy |=> (ch1_recv_rdy || hold));

  assert_ch2_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ch2_send_rdy && !ch1_send_rdy) |=> (ch2_recv_rdy || hold));

  assert_one_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ch2_recv_rdy, ch1_recv_rdy}));

  assert_idle_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch1_send_rdy && !ch2_send_rdy) |=> (!ch1_recv_rdy && !ch2_recv_rdy));

  assert_ch1_deliver_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ch1_send_rdy && ch1_recv_rdy) |=>
      (out_vld && !out_from && out_word == $past(ch1_data)));

  assert_ch2_deliver_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ch2_send_rdy && ch2_recv_rdy) |=>
      (out_vld && out_from && out_word == $past(ch2_data)));

  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !((ch1_send_rdy && ch1_recv_rdy) || (ch2_send_rdy && ch2_recv_rdy)) |=> !out_vld);

  assert_hold_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (!ch1_recv_rdy && !ch2_recv_rdy));
endmodule

bind hsrx_top hsrx_chk #(.DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ch1_send_rdy (ch1_send_rdy),
  .ch1_data     (ch1_data),
  .ch1_recv_rdy (ch1_recv_rdy),
  .ch2_send_rdy (ch2_send_rdy),
  .ch2_data     (ch2_data),
  .ch2_recv_rdy (ch2_recv_rdy),
  .hold         (hold),
  .out_vld      (out_vld),
  .out_word     (out_word),
  .out_from     (out_from)
);

// File: tb/tb_hsrx_top.sv
module tb_hsrx_top;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ch1_send_rdy, ch2_send_rdy, hold;
  logic [DW-1:0] ch1_data, ch2_data;
  logic          ch1_recv_rdy, ch2_recv_rdy, out_vld, out_from;
  logic [DW-1:0] out_word;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  hsrx_top #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .ch1_send_rdy(ch1_send_rdy), .ch1_data(ch1_data), .ch1_recv_rdy(ch1_recv_rdy),
    .ch2_send_rdy(ch2_send_rdy), .ch2_data(ch2_data), .ch2_recv_rdy(ch2_recv_rdy),
    .hold(hold), .out_vld(out_vld), .out_word(out_word), .out_from(out_from)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_rdy(string req, logic e1, logic e2);
    chk(req, "ch1_recv_rdy", 32'(ch1_recv_rdy), 32'(e1));
    chk(req, "ch2_recv_rdy", 32'(ch2_recv_rdy), 32'(e2));
  endtask

  task automatic chk_out(string req, logic [DW-1:0] w, logic src);
    chk(req, "out_vld",  32'(out_vld),  32'd1);
    chk(req, "out_word", 32'(out_word), 32'(w));
    chk(req, "out_from", 32'(out_from), 32'(src));
  endtask

  // R1: outputs low under reset
  task automatic t_reset;
    rst_n = 1'b0; ch1_send_rdy = 0; ch2_send_rdy = 0; hold = 0;
    ch1_data = '0; ch2_data = '0;
    repeat (2) @(negedge clk);
    chk_rdy("R1", 0, 0);
    chk("R1", "out_vld", 32'(out_vld), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // R2, R5, R9, R10: single word on one channel, full-width pattern
  task automatic t_single(bit ch2, logic [DW-1:0] w);
    @(negedge clk);
    if (ch2) begin ch2_send_rdy = 1; ch2_data = w; end
    else     begin ch1_send_rdy = 1; ch1_data = w; end
    @(negedge clk);
    chk_rdy("R2", !ch2, ch2);
    chk("R2", "out_vld", 32'(out_vld), 32'd0);
    @(negedge clk);
    chk_out("R5_R9", w, ch2);
    ch1_send_rdy = 0; ch2_send_rdy = 0;
    ch1_data = ~w; ch2_data = ~w;
    @(negedge clk);
    chk("R10", "out_vld", 32'(out_vld), 32'd0);
    chk_rdy("R4", 0, 0);
  endtask

  // R2 priority, R3: both offer on the same edge
  task automatic t_priority;
    @(negedge clk);
    ch1_send_rdy = 1; ch1_data = 16'h1111;
    ch2_send_rdy = 1; ch2_data = 16'h2222;
    @(negedge clk);
    chk_rdy("R2_R3", 1, 0);
    @(negedge clk);
    chk_out("R5", 16'h1111, 0);
    chk_rdy("R3", 1, 0);
    ch1_send_rdy = 0;
    @(negedge clk);
    chk("R10", "out_vld", 32'(out_vld), 32'd0);
    chk_rdy("R2", 0, 1);
    @(negedge clk);
    chk_out("R5", 16'h2222, 1);
    ch2_send_rdy = 0;
    @(negedge clk);
    chk_rdy("R4", 0, 0);
    chk("R6", "out_vld", 32'(out_vld), 32'd0);
  endtask

  // R7: back-to-back stream of five words
  task automatic t_stream;
    @(negedge clk);
    ch1_send_rdy = 1; ch1_data = 16'h0100;
    @(negedge clk);
    chk_rdy("R7", 1, 0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk_out("R7", 16'(16'h0100 + k), 0);
      if (k < 4) ch1_data = 16'(16'h0101 + k);
      else       ch1_send_rdy = 0;
    end
    @(negedge clk);
    chk("R7", "out_vld", 32'(out_vld), 32'd0);
  endtask

  // R6, R4: data toggling with no offers is ignored
  task automatic t_ignore;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      ch1_data = 16'(16'hBEE0 + k); ch2_data = 16'(16'hC0D0 + k);
      chk("R6", "out_vld", 32'(out_vld), 32'd0);
      chk_rdy("R4", 0, 0);
    end
  endtask

  // R8: hold blocks acceptance, pending grant shows on release
  task automatic t_hold;
    @(negedge clk);
    hold = 1; ch1_send_rdy = 1; ch1_data = 16'h7E57;
    repeat (2) begin
      @(negedge clk);
      chk_rdy("R8", 0, 0);
      chk("R8", "out_vld", 32'(out_vld), 32'd0);
    end
    hold = 0;
    #1;
    chk_rdy("R8", 1, 0);
    @(negedge clk);
    chk_out("R8", 16'h7E57, 0);
    ch1_send_rdy = 0;
    @(negedge clk);
    chk("R8", "out_vld", 32'(out_vld), 32'd0);
  endtask

  // R1: reset in the middle of traffic
  task automatic t_reset_mid;
    @(negedge clk);
    ch2_send_rdy = 1; ch2_data = 16'h4444;
    @(negedge clk);
    chk_rdy("R2", 0, 1);
    rst_n = 0;
    #1;
    chk_rdy("R1", 0, 0);
    chk("R1", "out_vld", 32'(out_vld), 32'd0);
    ch2_send_rdy = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_rdy("R1", 0, 0);
  endtask

  initial begin
    t_reset();
    t_single(0, 16'hA5C3);
    t_single(1, 16'hFFFF);
    t_priority();
    t_stream();
    t_ignore();
    t_hold();
    t_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule